// File: doc/BRIEF.md
# Reference-Disciplined Fractional Clock Synthesizer

This block turns a slow, accurate reference pulse train (one rising edge per reference interval, for example once per second from a satellite timing receiver) into a fast square wave. The wave is generated from a free-running master clock whose frequency is allowed to wander. On every reference rising edge the block captures how many master cycles the previous interval lasted. It divides that count by the output-to-reference frequency ratio `RATIO` with a multi-cycle restoring divider. On the following reference edge it restarts the output wave from that quotient.

The quotient is the whole output period in master cycles. The high phase takes half of it, rounded down, and the low phase takes the rest. The remainder of the division feeds an accumulator. Whenever the accumulated remainders reach one whole master cycle, the low phase of that period gains one extra cycle. Across `RATIO` output periods this spreads the leftover cycles evenly, so the output stays in step with the reference. Another stage may supply a filtered period length in place of the raw measurement.

Top module: `ref_disciplined_synth`

## Requirements
- R1: After reset, and until the third synchronized reference rising edge following reset, `wave_out` and `wave_valid` are both 0. A reset applied in mid-run returns both to 0 and restarts this warm-up.
- R2: The measured length of an interval is the number of master cycles between two consecutive reference rising edges. The width of the high pulse on `ref_in` has no effect on it.
- R3: A length captured at reference edge k is divided during the interval that follows. It drives the output from reference edge k+1 onward, so the wave in interval n is built from the length of interval n-2.
- R4: For a used length P, the full output period is T = P div RATIO master cycles and the remainder is P mod RATIO.
- R5: Each output period is high for floor(T/2) cycles and then low for T - floor(T/2) cycles, plus any extra cycle from R6. An odd T therefore puts the spare cycle in the low phase.
- R6: Output periods are numbered j = 1, 2, ... from each reference edge. The low phase of period j gains one extra cycle exactly when floor(j*rem/RATIO) exceeds floor((j-1)*rem/RATIO), because the accumulator is cleared at each reference edge. The first RATIO periods therefore last exactly P cycles.
- R7: When a new period length is applied, `wave_out` goes to 1 on the third rising clock edge after `ref_in` is first sampled high. `wave_out` is 0 just before that edge whenever the prior interval ended in a low phase.
- R8: Once `wave_valid` is 1, it stays 1 until reset.
- R9: When `ext_sel` is 1 in the cycle after a reference edge, `ext_period` replaces the measured length as the dividend.
- R10: Measurement and division repeat on every reference edge. A change in interval length shows up in the output two intervals later.
- R11: While `ext_sel` is 0, the value on `ext_period` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous reference pulse; only its rising edge is used |
| ext_sel | input | 1 | Selects `ext_period` as the dividend when a length is captured |
| ext_period | input | CNT_W | Externally supplied (for example filtered) interval length in master cycles |
| wave_out | output | 1 | Synthesized square wave |
| wave_valid | output | 1 | High once the wave is built from a measured length |

## Verification
The checks assume that every reference interval is longer than the CNT_W cycles the divider needs. They also assume that each used length gives a full period T of at least 2, and that `ref_in` stays low for at least two master cycles between pulses. The stimulus meets all three: intervals are about 5000 cycles against a 16-cycle divider, T is about 400 to 500, and the pulse widths range from 1 to 300 cycles. The supplied external length is likewise kept large, and `ext_sel` is changed only far from any reference edge, so its sampling cycle is never ambiguous.

// File: rtl/rds_pkg.sv
package rds_pkg;

  // Number of flops between the asynchronous reference and the edge detector.
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_t;

endpackage

// File: rtl/rds_edge_sync.sv
module rds_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/rds_period_meter.sv
module rds_period_meter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             strobe_o,
  output logic [CNT_W-1:0] length_o
);

  logic [CNT_W-1:0] span_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q   <= '0;
      armed_q  <= 1'b0;
      strobe_o <= 1'b0;
      length_o <= '0;
    end else begin
      strobe_o <= 1'b0;
      if (edge_i) begin
        span_q  <= CNT_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          strobe_o <= 1'b1;
          length_o <= span_q;
        end
      end else if (span_q != '1) begin
        span_q <= span_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rds_seq_divider.sv
module rds_seq_divider
  import rds_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RATIO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] dividend_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] quot_o,
  output logic [CNT_W-1:0] rem_o
);

  localparam int unsigned STEP_W = (CNT_W < 2) ? 1 : $clog2(CNT_W);
  localparam logic [CNT_W-1:0] DIV_C = CNT_W'(RATIO);

  div_state_t        state_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  num_q;
  logic [CNT_W-1:0]  part_q;

  // One restoring step: shift in the next dividend bit and subtract if it fits.
  function automatic logic [CNT_W:0] restore_step(input logic [CNT_W-1:0] part,
                                                  input logic             next_bit);
    logic [CNT_W-1:0] low;
    logic             fits;
    low  = {part[CNT_W-2:0], next_bit};
    fits = part[CNT_W-1] | (low >= DIV_C);
    return {fits, fits ? (low - DIV_C) : low};
  endfunction

  logic [CNT_W:0] step_res;
  assign step_res = restore_step(part_q, num_q[CNT_W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      step_q  <= '0;
      num_q   <= '0;
      part_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        DIV_IDLE: begin
          if (start_i) begin
            state_q <= DIV_RUN;
            step_q  <= '0;
            num_q   <= dividend_i;
            part_q  <= '0;
          end
        end
        DIV_RUN: begin
          num_q  <= {num_q[CNT_W-2:0], step_res[CNT_W]};
          part_q <= step_res[CNT_W-1:0];
          step_q <= step_q + STEP_W'(1);
          if (step_q == STEP_W'(CNT_W - 1)) begin
            state_q <= DIV_IDLE;
            done_o  <= 1'b1;
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == DIV_RUN);
  assign quot_o = num_q;
  assign rem_o  = part_q;

endmodule

// File: rtl/rds_wave_gen.sv
module rds_wave_gen #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RATIO = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic             wave_o,
  output logic             valid_o,
  output logic             carry_o,
  output logic [CNT_W-1:0] act_period_o
);

  localparam logic [CNT_W-1:0] RATIO_C = CNT_W'(RATIO);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] act_rem_q;

  function automatic logic [CNT_W-1:0] high_len(input logic [CNT_W-1:0] t);
    return t >> 1;
  endfunction

  function automatic logic [CNT_W-1:0] low_len(input logic [CNT_W-1:0] t, input logic extra);
    return t - (t >> 1) + CNT_W'(extra);
  endfunction

  logic             phase_end;
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] acc_next;

  assign phase_end = valid_o && (cnt_q == '0);
  // acc and rem are both below RATIO, so the gap never underflows.
  assign gap       = RATIO_C - act_rem_q;
  assign carry_o   = phase_end && wave_o && (acc_q >= gap);
  assign acc_next  = carry_o ? (acc_q - gap) : (acc_q + act_rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wave_o       <= 1'b0;
      valid_o      <= 1'b0;
      cnt_q        <= '0;
      acc_q        <= '0;
      act_rem_q    <= '0;
      act_period_o <= '0;
    end else if (load_i) begin
      wave_o       <= 1'b1;
      valid_o      <= 1'b1;
      cnt_q        <= high_len(period_i) - CNT_W'(1);
      acc_q        <= '0;
      act_rem_q    <= rem_i;
      act_period_o <= period_i;
    end else if (phase_end) begin
      if (wave_o) begin
        wave_o <= 1'b0;
        cnt_q  <= low_len(act_period_o, carry_o) - CNT_W'(1);
        acc_q  <= acc_next;
      end else begin
        wave_o <= 1'b1;
        cnt_q  <= high_len(act_period_o) - CNT_W'(1);
      end
    end else if (valid_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ref_disciplined_synth.sv
module ref_disciplined_synth
  import rds_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned RATIO = 10_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             ext_sel,
  input  logic [CNT_W-1:0] ext_period,
  output logic             wave_out,
  output logic             wave_valid
);

  // Named internal events, brought out for the bound checker.
  logic             ref_edge;
  logic             meas_strobe;
  logic [CNT_W-1:0] meas_len;
  logic             div_busy;
  logic             div_done;
  logic [CNT_W-1:0] div_quot;
  logic [CNT_W-1:0] div_rem;
  logic             load_now;
  logic             carry;
  logic [CNT_W-1:0] act_period;

  logic             pend_ok_q;
  logic [CNT_W-1:0] pend_quot_q;
  logic [CNT_W-1:0] pend_rem_q;
  logic [CNT_W-1:0] dividend;

  rds_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ref_in),
    .rise_o  (ref_edge)
  );

  rds_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (ref_edge),
    .strobe_o (meas_strobe),
    .length_o (meas_len)
  );

  assign dividend = ext_sel ? ext_period : meas_len;

  rds_seq_divider #(.CNT_W(CNT_W), .RATIO(RATIO)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (meas_strobe),
    .dividend_i (dividend),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  // A finished division waits here until the next reference edge applies it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ok_q   <= 1'b0;
      pend_quot_q <= '0;
      pend_rem_q  <= '0;
    end else if (div_done) begin
      pend_ok_q   <= 1'b1;
      pend_quot_q <= div_quot;
      pend_rem_q  <= div_rem;
    end else if (load_now) begin
      pend_ok_q   <= 1'b0;
    end
  end

  assign load_now = ref_edge && pend_ok_q;

  rds_wave_gen #(.CNT_W(CNT_W), .RATIO(RATIO)) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_now),
    .period_i     (pend_quot_q),
    .rem_i        (pend_rem_q),
    .wave_o       (wave_out),
    .valid_o      (wave_valid),
    .carry_o      (carry),
    .act_period_o (act_period)
  );

endmodule

// File: rtl/ref_disciplined_synth_chk.sv
module ref_disciplined_synth_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_edge,
  input logic             meas_strobe,
  input logic             div_busy,
  input logic             load_now,
  input logic             carry,
  input logic             wave,
  input logic             valid,
  input logic [CNT_W-1:0] act_period
);

  // Length of the current high run, counted in the checker.
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= CNT_W'(1);
    else if (load_now) run_q <= CNT_W'(1);
    else if (!wave)    run_q <= CNT_W'(1);
    else               run_q <= run_q + CNT_W'(1);
  end

  p_quiet_until_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !wave);

  p_single_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> !ref_edge);

  p_div_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |-> !div_busy);

  p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wave) |-> ($past(run_q) == ($past(act_period) >> 1)));

  p_carry_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !load_now) |=> !wave);

  p_load_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (wave && valid));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);

  p_strobe_follows_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe |-> $past(ref_edge));

endmodule

bind ref_disciplined_synth ref_disciplined_synth_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_edge    (ref_edge),
  .meas_strobe (meas_strobe),
  .div_busy    (div_busy),
  .load_now    (load_now),
  .carry       (carry),
  .wave        (wave_out),
  .valid       (wave_valid),
  .act_period  (act_period)
);

// File: tb/ref_disciplined_synth_test.sv
module ref_disciplined_synth_test;

  localparam int CNT_W = 16;
  localparam int RATIO = 10;
  localparam int HMAX  = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_in = 1'b0;
  logic             ext_sel = 1'b0;
  logic [CNT_W-1:0] ext_period = CNT_W'(1234);
  logic             wave_out;
  logic             wave_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nint = 0;
  bit finished = 0;
  bit hist_w [HMAX];
  bit hist_v [HMAX];
  int starts [32];

  always #2.5 clk = ~clk;

  ref_disciplined_synth #(.CNT_W(CNT_W), .RATIO(RATIO)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .ext_sel    (ext_sel),
    .ext_period (ext_period),
    .wave_out   (wave_out),
    .wave_valid (wave_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Record outputs at the falling edge; inputs change right after.
  task automatic tick();
    @(negedge clk);
    if (cyc < HMAX) begin
      hist_w[cyc] = wave_out;
      hist_v[cyc] = wave_valid;
    end
    cyc++;
  endtask

  task automatic run_ref(input int len, input int width, input int new_sel, input int new_ext);
    for (int i = 0; i < len; i++) begin
      tick();
      if (i == 0) starts[nint] = cyc - 1;
      ref_in = (i < width);
      if (i == 100 && new_sel >= 0) begin
        ext_sel    = new_sel[0];
        ext_period = CNT_W'(new_ext);
      end
    end
    nint++;
  endtask

  // Expected wave level at offset k after a reload with length puse.
  function automatic bit exp_bit(input int puse, input int k);
    int t, r, hi, lo, pos, j;
    t = puse / RATIO;
    r = puse % RATIO;
    hi = t / 2;
    pos = k;
    j = 1;
    forever begin
      lo = (t - hi) + ((j * r) / RATIO - ((j - 1) * r) / RATIO);
      if (pos < hi) return 1'b1;
      pos -= hi;
      if (pos < lo) return 1'b0;
      pos -= lo;
      j++;
    end
  endfunction

  task automatic check_wave(input int k, input int puse, input string req);
    int s, win, bad_at;
    bit bad_exp;
    s = starts[k] + 3;
    win = starts[k+1] - starts[k];
    if (puse < win) win = puse;
    bad_at = -1;
    bad_exp = 0;
    for (int o = 0; o < win; o++) begin
      if (bad_at < 0 && hist_w[s+o] != exp_bit(puse, o)) begin
        bad_at = o;
        bad_exp = exp_bit(puse, o);
      end
    end
    check(bad_at < 0, req, $sformatf("interval %0d wave mismatch at offset %0d", k, bad_at),
          (bad_at < 0) ? 0 : int'(hist_w[s+bad_at]), (bad_at < 0) ? 0 : int'(bad_exp));
  endtask

  task automatic check_idle(input int from, input int upto, input string req);
    int bad;
    bad = 0;
    for (int c = from; c <= upto; c++) if (hist_w[c] || hist_v[c]) bad++;
    check(bad == 0, req, "cycles with wave or valid set during warm-up", bad, 0);
  endtask

  task automatic check_valid(input int from, input int upto, input string req);
    int bad;
    bad = 0;
    for (int c = from; c <= upto; c++) if (!hist_v[c]) bad++;
    check(bad == 0, req, "cycles with valid low after lock", bad, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check(!wave_out && !wave_valid, "R1", "outputs in reset", {wave_out, wave_valid}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) tick();
  endtask

  task automatic t_warmup_and_steady();
    run_ref(5003, 20, -1, 0);
    run_ref(5003, 20, -1, 0);
    run_ref(5003, 300, -1, 0);
    run_ref(5003, 1, -1, 0);
    check_idle(0, starts[2] + 2, "R1");
    check(hist_w[starts[2]+3] == 1'b1, "R7", "wave on third edge after ref high",
          int'(hist_w[starts[2]+3]), 1);
    check(hist_v[starts[2]+3] == 1'b1, "R1", "valid at first reload", int'(hist_v[starts[2]+3]), 1);
    check_wave(2, 5003, "R4");
    check_wave(3, 5003, "R2");
  endtask

  task automatic t_drift_and_ext();
    run_ref(5000, 20, -1, 0);
    run_ref(5009, 40, -1, 0);
    run_ref(5010, 20, -1, 0);
    run_ref(5013, 5, -1, 0);
    run_ref(5003, 20, 1, 4004);
    run_ref(5000, 20, 0, 4004);
    run_ref(5000, 20, -1, 0);
    run_ref(5000, 20, -1, 0);
    run_ref(5000, 20, -1, 0);
    check_wave(4, 5003, "R3");
    check(hist_w[starts[4]+2] == 1'b0 && hist_w[starts[4]+3] == 1'b1, "R7",
          "reload edge at interval 4", int'(hist_w[starts[4]+3]), 1);
    check_wave(5, 5003, "R6");
    check_wave(6, 5000, "R10");
    check_wave(7, 5009, "R6");
    check_wave(8, 5010, "R5");
    check_wave(9, 5013, "R6");
    check_wave(10, 4004, "R9");
    check_wave(11, 5000, "R11");
    check_valid(starts[2] + 3, starts[12] + 10, "R8");
  endtask

  task automatic t_midrun_reset();
    int base, m0;
    base = cyc;
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    check(!wave_out && !wave_valid, "R1", "outputs after mid-run reset", {wave_out, wave_valid}, 0);
    rst_n = 1'b1;
    m0 = nint;
    run_ref(5000, 20, -1, 0);
    run_ref(5000, 20, -1, 0);
    run_ref(5000, 20, -1, 0);
    for (int i = 0; i < 6; i++) tick();
    check_idle(base + 1, starts[m0+2] + 2, "R1");
    check(hist_w[starts[m0+2]+3] == 1'b1 && hist_v[starts[m0+2]+3] == 1'b1, "R7",
          "wave after relock", int'(hist_w[starts[m0+2]+3]), 1);
  endtask

  initial begin
    t_reset_state();
    t_warmup_and_steady();
    t_drift_and_ext();
    t_midrun_reset();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule